// File: doc/BRIEF.md
# Prescaled Multi-Timer with Watchdog

This block holds one shared clock prescaler and a parameterised number (1 to 7) of down-counting timers. Software reaches all of them through a flat register port with a write strobe, an address, write data and combinational read data. The prescaler counts down to zero and then reloads. On the cycle it sits at zero it produces a common tick, and every enabled timer steps on that tick. Each timer has a counter, a reload value and a control word.

When a timer steps below zero it raises its pending flag and pulses an interrupt line. It then either reloads or stops, depending on its restart bit. Interrupt lines start at a base index. With separate lines selected, each later timer takes the next index. Otherwise all timers share the base line.

As an option, the highest-numbered timer serves as a watchdog. Reset loads it with a fixed count and sets it running with no software action. When it expires it drives a watchdog flag that stays set until the next reset.

Top module: `mtim_top`

## Requirements
- R1: While reset is held, the prescaler counter and reload read all ones. Every non-watchdog timer reads counter 0, reload 0 and control 0. The interrupt vector and the watchdog flag are low.
- R2: Register map: address 0 is the prescaler counter and address 1 is the prescaler reload. The prescaler counter decrements by one per clock. In the cycle after it reads 0 it holds the reload value, so with reload R the tick repeats every R+1 clocks.
- R3: Timer n sits at base address 4+4n: counter at +0, reload at +1, control at +2. An enabled timer decrements once per prescaler tick. A disabled timer holds its count.
- R4: Control bits are: bit 0 enable, bit 1 restart, bit 2 load, bit 3 pending. A tick that finds an enabled timer at 0 sets its pending bit. The same edge raises its interrupt line for exactly one clock.
- R5: On that underflow, a timer with restart set takes its reload value. Otherwise its counter becomes all ones and its enable bit clears.
- R6: Writing control with bit 2 set copies the reload value into the counter at that edge. Bit 2 always reads back 0.
- R7: Timer n drives interrupt line BASE+n when separate lines are selected. When they are not, every timer drives line BASE. No other line ever rises.
- R8: With the watchdog enabled, reset loads the last timer's counter and reload with the fixed value and sets its enable bit. It then counts on prescaler ticks. Its underflow sets the watchdog flag, which stays high until reset.
- R9: A write to a counter address places the written value in that counter at the next edge, and no decrement happens in that cycle.
- R10: A control write replaces the pending bit with bit 3 of the write data, so writing 0 there clears it. An underflow in the same cycle still sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | NIRQ | Interrupt lines, one-clock pulse per underflow |
| wdog_out | output | 1 | Sticky watchdog expiry flag |

## Verification
The checker assumes the register port is quiet in any cycle used as a counting reference. Its stability and tick-spacing properties therefore only apply in cycles with reg_wr low. It also assumes software never writes a reload and a counter in the same cycle, which a single-address port cannot do anyway.

The stimulus keeps every timer disabled while it rewrites the prescaler to set a known phase. It enables a timer only after that phase is fixed, so each expected count, interrupt pulse and expiry falls on a clock edge the bench can compute. A second instance with shared interrupt lines receives the same writes, so both line-numbering modes are observed on identical underflows.

// File: rtl/mtim_pkg.sv
`timescale 1ns/1ps
package mtim_pkg;
   // control word bit positions
   localparam int CTL_EN = 0;
   localparam int CTL_RS = 1;
   localparam int CTL_LD = 2;
   localparam int CTL_IP = 3;
   localparam int CTL_W  = 4;

   // register map
   localparam int REG_DW       = 32;
   localparam int PRE_CNT_ADR  = 0;
   localparam int PRE_RLD_ADR  = 1;
   localparam int TMR_BASE_ADR = 4;
   localparam int TMR_STRIDE   = 4;
   localparam int OFS_CNT      = 0;
   localparam int OFS_RLD      = 1;
   localparam int OFS_CTL      = 2;

   typedef struct packed {
      logic cnt;
      logic rld;
      logic ctl;
   } tmr_wr_t;
endpackage

// File: rtl/mtim_prescaler.sv
`timescale 1ns/1ps
module mtim_prescaler #(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_cnt,
   input  logic          wr_rld,
   input  logic [PW-1:0] wdata,
   output logic [PW-1:0] cnt_o,
   output logic [PW-1:0] rld_o,
   output logic          tick_o
);
   logic [PW-1:0] cnt_q, rld_q;

   assign tick_o = (cnt_q == '0);
   assign cnt_o  = cnt_q;
   assign rld_o  = rld_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= '1;
         rld_q <= '1;
      end else begin
         if (wr_rld)
            rld_q <= wdata;
         if (wr_cnt)
            cnt_q <= wdata;
         else if (tick_o)
            cnt_q <= rld_q;
         else
            cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/mtim_timer.sv
`timescale 1ns/1ps
module mtim_timer
   import mtim_pkg::*;
#(
   parameter int          TW      = 16,
   parameter bit          IS_WD   = 1'b0,
   parameter int unsigned WD_INIT = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  tmr_wr_t          wr,
   input  logic [TW-1:0]    d_val,
   input  logic [CTL_W-1:0] d_ctl,
   output logic [TW-1:0]    cnt_o,
   output logic [TW-1:0]    rld_o,
   output logic             en_o,
   output logic             rs_o,
   output logic             ip_o,
   output logic             uf_o
);
   localparam logic [TW-1:0] RST_VAL = IS_WD ? TW'(WD_INIT) : '0;

   logic [TW-1:0] cnt_q, rld_q;
   logic          en_q, rs_q, ip_q;
   logic          ld, step;

   assign ld   = wr.ctl && d_ctl[CTL_LD];
   assign step = en_q && tick && !wr.cnt && !ld;
   assign uf_o = step && (cnt_q == '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt_q <= RST_VAL;
         rld_q <= RST_VAL;
         en_q  <= IS_WD;
         rs_q  <= 1'b0;
         ip_q  <= 1'b0;
      end else begin
         if (wr.rld)
            rld_q <= d_val;

         if (wr.cnt)
            cnt_q <= d_val;
         else if (ld)
            cnt_q <= rld_q;
         else if (step)
            cnt_q <= (cnt_q != '0) ? cnt_q - 1'b1 : (rs_q ? rld_q : '1);

         if (wr.ctl) begin
            en_q <= d_ctl[CTL_EN];
            rs_q <= d_ctl[CTL_RS];
         end else if (uf_o && !rs_q) begin
            en_q <= 1'b0;
         end

         ip_q <= (wr.ctl ? d_ctl[CTL_IP] : ip_q) | uf_o;
      end
   end

   assign cnt_o = cnt_q;
   assign rld_o = rld_q;
   assign en_o  = en_q;
   assign rs_o  = rs_q;
   assign ip_o  = ip_q;
endmodule

// File: rtl/mtim_irq_map.sv
`timescale 1ns/1ps
module mtim_irq_map #(
   parameter int NT   = 4,
   parameter int NIRQ = 32,
   parameter int BASE = 4,
   parameter bit SEP  = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NT-1:0]   uf,
   output logic [NIRQ-1:0] irq_o
);
   logic [NIRQ-1:0] line;

   if (SEP) begin : g_sep
      always_comb begin
         line = '0;
         for (int i = 0; i < NT; i++)
            line[BASE+i] = uf[i];
      end
   end else begin : g_shared
      always_comb begin
         line       = '0;
         line[BASE] = |uf;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) irq_o <= '0;
      else     irq_o <= line;
   end
endmodule

// File: rtl/mtim_top.sv
`timescale 1ns/1ps
module mtim_top
   import mtim_pkg::*;
#(
   parameter int          NT        = 4,
   parameter int          PRE_W     = 8,
   parameter int          TMR_W     = 16,
   parameter int          ADDR_W    = 6,
   parameter int          NIRQ      = 32,
   parameter int          IRQ_BASE  = 4,
   parameter bit          SEP_IRQ   = 1'b1,
   parameter bit          WDOG_EN   = 1'b1,
   parameter int unsigned WDOG_INIT = 32'h0000_FFFF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NIRQ-1:0]   irq_out,
   output logic              wdog_out
);
   localparam int WD_IDX   = NT - 1;
   localparam int LAST_ADR = TMR_BASE_ADR + TMR_STRIDE*(NT-1) + OFS_CTL;
   localparam int TOP_LINE = SEP_IRQ ? IRQ_BASE + NT - 1 : IRQ_BASE;

   // elaboration-time parameter checks
   if (NT < 1 || NT > 7) begin : g_chk_nt
      $error("mtim_top: NT must lie in 1..7");
   end
   if (PRE_W < 2 || PRE_W > 16) begin : g_chk_pw
      $error("mtim_top: PRE_W must lie in 2..16");
   end
   if (TMR_W < 2 || TMR_W > 32) begin : g_chk_tw
      $error("mtim_top: TMR_W must lie in 2..32");
   end
   if (LAST_ADR >= (1 << ADDR_W)) begin : g_chk_aw
      $error("mtim_top: ADDR_W too narrow for the register map");
   end
   if (IRQ_BASE < 0 || TOP_LINE >= NIRQ) begin : g_chk_irq
      $error("mtim_top: interrupt lines exceed NIRQ");
   end
   if (WDOG_EN && TMR_W < 32 && 64'(WDOG_INIT) >= (64'd1 << TMR_W)) begin : g_chk_wd
      $error("mtim_top: WDOG_INIT does not fit TMR_W");
   end

   // prescaler
   logic             pre_tick;
   logic [PRE_W-1:0] pre_cnt, pre_rld;
   logic             pre_wr_cnt, pre_wr_rld;

   assign pre_wr_cnt = reg_wr && (reg_addr == ADDR_W'(PRE_CNT_ADR));
   assign pre_wr_rld = reg_wr && (reg_addr == ADDR_W'(PRE_RLD_ADR));

   mtim_prescaler #(.PW(PRE_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .wr_cnt (pre_wr_cnt),
      .wr_rld (pre_wr_rld),
      .wdata  (reg_wdata[PRE_W-1:0]),
      .cnt_o  (pre_cnt),
      .rld_o  (pre_rld),
      .tick_o (pre_tick)
   );

   // timers
   logic [NT-1:0][TMR_W-1:0] tmr_cnt, tmr_rld;
   logic [NT-1:0]            tmr_en, tmr_rs, tmr_ip, tmr_uf;

   for (genvar i = 0; i < NT; i++) begin : g_tmr
      localparam int BA = TMR_BASE_ADR + TMR_STRIDE*i;
      tmr_wr_t wsel;

      assign wsel.cnt = reg_wr && (reg_addr == ADDR_W'(BA + OFS_CNT));
      assign wsel.rld = reg_wr && (reg_addr == ADDR_W'(BA + OFS_RLD));
      assign wsel.ctl = reg_wr && (reg_addr == ADDR_W'(BA + OFS_CTL));

      mtim_timer #(
         .TW      (TMR_W),
         .IS_WD   (WDOG_EN && (i == WD_IDX)),
         .WD_INIT (WDOG_INIT)
      ) u_tmr (
         .clk   (clk),
         .rst   (rst),
         .tick  (pre_tick),
         .wr    (wsel),
         .d_val (reg_wdata[TMR_W-1:0]),
         .d_ctl (reg_wdata[CTL_W-1:0]),
         .cnt_o (tmr_cnt[i]),
         .rld_o (tmr_rld[i]),
         .en_o  (tmr_en[i]),
         .rs_o  (tmr_rs[i]),
         .ip_o  (tmr_ip[i]),
         .uf_o  (tmr_uf[i])
      );
   end

   // interrupt lines
   mtim_irq_map #(
      .NT   (NT),
      .NIRQ (NIRQ),
      .BASE (IRQ_BASE),
      .SEP  (SEP_IRQ)
   ) u_irq (
      .clk   (clk),
      .rst   (rst),
      .uf    (tmr_uf),
      .irq_o (irq_out)
   );

   // watchdog flag
   if (WDOG_EN) begin : g_wd
      logic wd_q;
      always_ff @(posedge clk or posedge rst) begin
         if (rst)                 wd_q <= 1'b0;
         else if (tmr_uf[WD_IDX]) wd_q <= 1'b1;
      end
      assign wdog_out = wd_q;
   end else begin : g_no_wd
      assign wdog_out = 1'b0;
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(PRE_CNT_ADR))
         reg_rdata = 32'(pre_cnt);
      if (reg_addr == ADDR_W'(PRE_RLD_ADR))
         reg_rdata = 32'(pre_rld);
      for (int i = 0; i < NT; i++) begin
         if (reg_addr == ADDR_W'(TMR_BASE_ADR + TMR_STRIDE*i + OFS_CNT))
            reg_rdata = 32'(tmr_cnt[i]);
         if (reg_addr == ADDR_W'(TMR_BASE_ADR + TMR_STRIDE*i + OFS_RLD))
            reg_rdata = 32'(tmr_rld[i]);
         if (reg_addr == ADDR_W'(TMR_BASE_ADR + TMR_STRIDE*i + OFS_CTL))
            reg_rdata = 32'({tmr_ip[i], 1'b0, tmr_rs[i], tmr_en[i]});
      end
   end

   wire unused_wdata = ^reg_wdata;
endmodule

// File: rtl/mtim_sva.sv
`timescale 1ns/1ps
module mtim_sva #(
   parameter int NT       = 4,
   parameter int TW       = 16,
   parameter int PW       = 8,
   parameter int ADDR_W   = 6,
   parameter int NIRQ     = 32,
   parameter int IRQ_BASE = 4,
   parameter bit SEP      = 1'b1,
   parameter bit WDOG_EN  = 1'b1
) (
   input logic                clk,
   input logic                rst,
   input logic                reg_wr,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [NIRQ-1:0]     irq_out,
   input logic                wdog_out,
   input logic                pre_tick,
   input logic [PW-1:0]       pre_rld,
   input logic [NT-1:0][TW-1:0] cnt,
   input logic [NT-1:0]       en,
   input logic [NT-1:0]       rs,
   input logic [NT-1:0]       ip,
   input logic [NT-1:0]       uf
);
   function automatic logic [NIRQ-1:0] line_mask();
      logic [NIRQ-1:0] m;
      m = '0;
      for (int i = 0; i < NT; i++)
         m[SEP ? IRQ_BASE + i : IRQ_BASE] = 1'b1;
      return m;
   endfunction

   localparam logic [NIRQ-1:0] LINE_MASK = line_mask();
   localparam int WD_LINE = SEP ? IRQ_BASE + NT - 1 : IRQ_BASE;

   // R2: a nonzero reload keeps ticks at least two clocks apart
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
      (pre_tick && pre_rld != '0 && !reg_wr) |=> !pre_tick);

   // R4: a raised interrupt line always has a pending bit behind it
   a_r4_irq_has_pending: assert property (@(posedge clk) disable iff (rst)
      (|irq_out) |-> (|ip));

   // R7: only the mapped lines may ever rise
   a_r7_line_range: assert property (@(posedge clk) disable iff (rst)
      (irq_out & ~LINE_MASK) == '0);

   // R8: the watchdog flag never drops outside reset
   a_r8_wdog_sticky: assert property (@(posedge clk) disable iff (rst)
      wdog_out |=> wdog_out);

   for (genvar i = 0; i < NT; i++) begin : g_t
      localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(4 + 4*i + 2);

      // R3: without a tick and without a write, a counter holds
      a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
         (!pre_tick && !reg_wr) |=> $stable(cnt[i]));

      // R5: underflow without restart leaves the timer disabled
      a_r5_stop_on_uf: assert property (@(posedge clk) disable iff (rst)
         (uf[i] && !rs[i] && !(reg_wr && reg_addr == CTL_A)) |=> !en[i]);

      // R4: an underflow leaves the pending bit set
      a_r4_uf_sets_pending: assert property (@(posedge clk) disable iff (rst)
         uf[i] |=> ip[i]);
   end

   if (WDOG_EN) begin : g_wd
      // R8: the flag rises together with the watchdog timer's line
      a_r8_wdog_cause: assert property (@(posedge clk) disable iff (rst)
         $rose(wdog_out) |-> irq_out[WD_LINE]);
   end
endmodule

bind mtim_top mtim_sva #(
   .NT       (NT),
   .TW       (TMR_W),
   .PW       (PRE_W),
   .ADDR_W   (ADDR_W),
   .NIRQ     (NIRQ),
   .IRQ_BASE (IRQ_BASE),
   .SEP      (SEP_IRQ),
   .WDOG_EN  (WDOG_EN)
) u_sva (
   .clk      (clk),
   .rst      (rst),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .irq_out  (irq_out),
   .wdog_out (wdog_out),
   .pre_tick (pre_tick),
   .pre_rld  (pre_rld),
   .cnt      (tmr_cnt),
   .en       (tmr_en),
   .rs       (tmr_rs),
   .ip       (tmr_ip),
   .uf       (tmr_uf)
);

// File: tb/tb_mtim_top.sv
`timescale 1ns/1ps
module tb_mtim_top;
   localparam int NT   = 4;
   localparam int PW   = 8;
   localparam int TW   = 16;
   localparam int AW   = 6;
   localparam int NIRQ = 32;
   localparam int BASE = 4;
   localparam int WDI  = 40;

   // chk kinds
   localparam int K_RD  = 0;
   localparam int K_IRQ = 1;
   localparam int K_SHR = 2;
   localparam int K_WD  = 3;

   logic            clk = 1'b0;
   logic            rst;
   logic            reg_wr;
   logic [AW-1:0]   reg_addr;
   logic [31:0]     reg_wdata;
   logic [31:0]     reg_rdata, shr_rdata;
   logic [NIRQ-1:0] irq_out, shr_irq;
   logic            wdog_out, shr_wdog;

   always #2.5 clk = ~clk;

   mtim_top #(
      .NT(NT), .PRE_W(PW), .TMR_W(TW), .ADDR_W(AW), .NIRQ(NIRQ),
      .IRQ_BASE(BASE), .SEP_IRQ(1'b1), .WDOG_EN(1'b1), .WDOG_INIT(WDI)
   ) dut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .wdog_out(wdog_out)
   );

   mtim_top #(
      .NT(2), .PRE_W(PW), .TMR_W(TW), .ADDR_W(AW), .NIRQ(NIRQ),
      .IRQ_BASE(BASE), .SEP_IRQ(1'b0), .WDOG_EN(1'b0), .WDOG_INIT(0)
   ) dut_shr (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(shr_rdata),
      .irq_out(shr_irq), .wdog_out(shr_wdog)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t exp_q[$];
   event  ev_item;
   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(ev_item);
         while (exp_q.size() != 0) begin
            item_t       it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
               K_RD:    act = reg_rdata;
               K_IRQ:   act = irq_out;
               K_SHR:   act = shr_irq;
               default: act = {31'd0, wdog_out};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
         end
      end
   end

   // driver tasks
   task automatic chk(int kind, logic [AW-1:0] a, logic [31:0] e, string tag);
      reg_addr = a;
      #0.05;
      exp_q.push_back('{kind, e, tag});
      -> ev_item;
      #0.05;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_run();
      end
   end

   initial begin
      rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      cyc(3);
      // R1: reset state
      chk(K_RD, 0, 32'h0000_00FF, "R1 prescaler count");
      chk(K_RD, 1, 32'h0000_00FF, "R1 prescaler reload");
      chk(K_RD, 4, 32'd0, "R1 timer0 count");
      chk(K_RD, 5, 32'd0, "R1 timer0 reload");
      chk(K_RD, 6, 32'd0, "R1 timer0 control");
      chk(K_IRQ, 0, 32'd0, "R1 irq low");
      chk(K_WD, 0, 32'd0, "R1 watchdog low");
      chk(K_RD, 16, WDI, "R8 watchdog reset count");
      chk(K_RD, 18, 32'd1, "R8 watchdog reset enabled");
      rst = 1'b0;
      wr(18, 0);                     // park the watchdog

      // R2: prescaler sequence with reload 3
      wr(1, 3);
      wr(0, 3);
      chk(K_RD, 0, 3, "R2 count after write");
      for (int k = 2; k >= 0; k--) begin
         cyc(1);
         chk(K_RD, 0, k, "R2 count step");
      end
      cyc(1);
      chk(K_RD, 0, 3, "R2 reload after zero");

      // R9 / R3: direct counter write, disabled hold
      wr(5, 5);
      wr(4, 2);
      chk(K_RD, 4, 2, "R9 counter write");
      cyc(8);
      chk(K_RD, 4, 2, "R3 disabled timer holds");

      // timer0 with restart: ticks land on the 3rd edge after the enable write
      wr(0, 3);
      wr(6, 3);
      cyc(3);
      chk(K_RD, 4, 1, "R3 first decrement");
      cyc(4);
      chk(K_RD, 4, 0, "R3 second decrement");
      chk(K_IRQ, 0, 0, "R4 no irq before underflow");
      cyc(4);
      chk(K_RD, 4, 5, "R5 restart reload");
      chk(K_IRQ, 0, 32'd1 << BASE, "R4 R7 timer0 line");
      chk(K_SHR, 0, 32'd1 << BASE, "R7 shared line timer0");
      chk(K_RD, 6, 11, "R4 pending set");
      cyc(1);
      chk(K_IRQ, 0, 0, "R4 one clock pulse");
      wr(6, 3);
      chk(K_RD, 6, 3, "R10 pending cleared");
      wr(6, 0);
      cyc(4);
      chk(K_RD, 4, 5, "R3 disabled across tick");

      // timer1 without restart
      wr(9, 7);
      wr(8, 1);
      wr(0, 3);
      wr(10, 1);
      cyc(3);
      chk(K_RD, 8, 0, "R3 timer1 decrement");
      cyc(4);
      chk(K_RD, 8, 32'h0000_FFFF, "R5 wrap to all ones");
      chk(K_RD, 10, 8, "R5 enable cleared, pending set");
      chk(K_IRQ, 0, 32'd1 << (BASE + 1), "R7 separate line timer1");
      chk(K_SHR, 0, 32'd1 << BASE, "R7 shared line timer1");
      cyc(4);
      chk(K_RD, 8, 32'h0000_FFFF, "R5 stopped timer holds");

      // R6 load bit
      wr(10, 4);
      chk(K_RD, 8, 7, "R6 load copies reload");
      chk(K_RD, 10, 0, "R6 load reads zero");

      // R8 watchdog expiry
      wr(16, 1);
      wr(0, 3);
      wr(18, 1);
      cyc(3);
      chk(K_RD, 16, 0, "R8 watchdog decrement");
      chk(K_WD, 0, 0, "R8 flag low before expiry");
      cyc(4);
      chk(K_WD, 0, 1, "R8 flag on expiry");
      chk(K_IRQ, 0, 32'd1 << (BASE + 3), "R8 watchdog line");
      wr(18, 3);
      wr(16, 100);
      cyc(10);
      chk(K_WD, 0, 1, "R8 flag sticky");

      // reset re-arms the watchdog, which runs unaided
      rst = 1'b1;
      cyc(2);
      chk(K_WD, 0, 0, "R1 flag cleared by reset");
      chk(K_RD, 18, 1, "R8 re-armed");
      rst = 1'b0;
      cyc(255);
      chk(K_RD, 16, WDI, "R8 no step before first tick");
      cyc(1);
      chk(K_RD, 16, WDI - 1, "R8 counts without software");

      cyc(2);
      done = 1;
      finish_run();
   end
endmodule